// File: doc/BRIEF.md
# Maskable Interrupt Status Unit

This unit gathers four event sources from a command-processing datapath into one interrupt status register. The sources are data available, status valid, locality change and command ready. Each event arrives as a single-cycle pulse and latches a sticky status bit. Software clears a status bit by writing a one to it.

A single interrupt line is driven from the latched bits. Three things gate it: a per-source enable, a global enable, and a trigger mode. The trigger mode picks active-high level, active-low level, a high pulse or a low pulse. A vector register holds the interrupt line number for software. A read-only capability word lists the sources and trigger modes this unit supports.

All registers are 32 bits wide. They sit on a simple synchronous bus with a write strobe and a read strobe. Read data is registered and appears one cycle after the read strobe. The interrupt output is also registered.

Top module: `irq_status_unit`

## Requirements
- R1: After reset, the enable, vector and status registers read zero, `irq_out` is low and `rdata` is zero.
- R2: Register addresses and read timing:
  - The enable register is at byte address 0x08. The vector register is at 0x0C and keeps 8 bits.
  - Only bits 31, 7, 4, 3, 2, 1 and 0 of the enable register are kept; its readback mask is 0x8000009F.
  - Any other address reads zero.
  - `rdata` holds the addressed value in the cycle after `rd_en` is sampled.
- R3: The capability register at 0x14 reads 0x000001FF with the burst-static parameter at its default of 1, and writes to it change nothing.
  - Bits 0, 1, 2 and 7 list the sources.
  - Bit 3 lists high level, bit 4 low level, bit 5 rising edge and bit 6 falling edge.
  - Bit 8 is the static burst count flag.
- R4: Each event pulse sets its status bit at 0x10, whatever the enables hold. The mapping is `ev_pulse[0]` to bit 0 (data available), `[1]` to bit 1 (status valid), `[2]` to bit 2 (locality change) and `[3]` to bit 7 (command ready).
- R5: Writing a one to a status bit clears it. Writing a zero leaves it unchanged. Status bits other than 0, 1, 2 and 7 always read zero.
- R6: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R7: While enable bit 31 (global enable) is clear, `irq_out` rests at its idle level. The idle level is low for modes 00 and 10 and high for modes 01 and 11.
- R8: Enable bits 4:3 select the trigger mode. In mode 00 (high level), `irq_out` is high one cycle after the global enable is set and some status bit is set together with its source enable; otherwise `irq_out` is low.
- R9: In mode 01 (low level), `irq_out` is the inverse of the mode-00 output.
- R10: In mode 10 (rising pulse), `irq_out` goes high for exactly one cycle after the set of enabled pending bits gains a member. A bit that is already pending and gets a repeated event gives no pulse. Enabling a bit that is already set counts as a new member.
- R11: In mode 11 (falling pulse), `irq_out` rests high and drops low for one cycle under the same condition as R10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W (8) | Byte address of the register |
| wdata | input | 32 | Write data |
| ev_pulse | input | 4 | Single-cycle event pulses: data available, status valid, locality change, command ready |
| rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Interrupt line with the selected polarity and mode |

## Verification
The assertions check the following on every cycle:
- an event always leaves its status bit set;
- a clear without a coincident event empties the bit;
- untouched bits hold their value;
- a cleared global enable keeps the line at its idle level;
- a rising pulse only follows a non-empty pending set;
- the capability word never changes.

Some behaviours depend on register history, and only the bench scenarios show them:
- one pulse per newly enabled pending bit and no pulse on a repeated event;
- the polarity swap between the two level modes;
- set-wins when an event collides with a clear;
- the exact cycle in which the output moves after a write.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
package irq_pkg;

  localparam int NSRC = 4;

  localparam int ADR_ENABLE = 'h08;
  localparam int ADR_VECTOR = 'h0C;
  localparam int ADR_STATUS = 'h10;
  localparam int ADR_CAPS   = 'h14;

  localparam int GIE_BIT    = 31;
  localparam int MODE_LO    = 3;
  localparam int BURST_BIT  = 8;

  typedef enum logic [1:0] {
    TRIG_LVL_HI   = 2'b00,
    TRIG_LVL_LO   = 2'b01,
    TRIG_EDGE_HI  = 2'b10,
    TRIG_EDGE_LO  = 2'b11
  } trig_mode_e;

  // register bit position of source index i
  function automatic int src_bit(input int i);
    case (i)
      0:       return 0;
      1:       return 1;
      2:       return 2;
      default: return 7;
    endcase
  endfunction

endpackage

// File: rtl/irq_status_bank.sv
`timescale 1ns/1ps
module irq_status_bank #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] ev_pulse,
  input  logic [NSRC-1:0] clr_mask,
  output logic [NSRC-1:0] status
);

  for (genvar g = 0; g < NSRC; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)
        status[g] <= 1'b0;
      else if (ev_pulse[g])
        status[g] <= 1'b1;     // set has priority over clear
      else if (clr_mask[g])
        status[g] <= 1'b0;
    end

    // R4: an event always leaves its bit set
    a_r4_event_sets: assert property (@(posedge clk) disable iff (rst)
      ev_pulse[g] |=> status[g]);
    // R5: clear without event empties the bit
    a_r5_clear_works: assert property (@(posedge clk) disable iff (rst)
      (clr_mask[g] && !ev_pulse[g]) |=> !status[g]);
    // R5: neither event nor clear keeps the bit
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
      (!clr_mask[g] && !ev_pulse[g]) |=> $stable(status[g]));
  end

endmodule

// File: rtl/irq_ctrl_regs.sv
`timescale 1ns/1ps
module irq_ctrl_regs
  import irq_pkg::*;
#(
  parameter int   ADDR_W       = 8,
  parameter int   DATA_W       = 32,
  parameter int   VEC_W        = 8,
  parameter logic BURST_STATIC = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NSRC-1:0]   status,
  output logic [NSRC-1:0]   src_en,
  output logic              gie,
  output trig_mode_e        mode,
  output logic [NSRC-1:0]   clr_mask,
  output logic [DATA_W-1:0] rdata
);

  localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(ADR_ENABLE);
  localparam logic [ADDR_W-1:0] A_VEC = ADDR_W'(ADR_VECTOR);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(ADR_STATUS);
  localparam logic [ADDR_W-1:0] A_CAP = ADDR_W'(ADR_CAPS);

  function automatic logic [DATA_W-1:0] caps_word();
    logic [DATA_W-1:0] c;
    c = '0;
    for (int i = 0; i < NSRC; i++) c[src_bit(i)] = 1'b1;
    for (int m = 0; m < 4; m++)    c[MODE_LO + m] = 1'b1;
    c[BURST_BIT] = BURST_STATIC;
    return c;
  endfunction

  localparam logic [DATA_W-1:0] CAP_VAL = caps_word();

  logic [VEC_W-1:0]  vector;
  logic              wr_en_reg, wr_vec, wr_sts;
  logic [DATA_W-1:0] rd_mux;
  logic              unused_wdata;

  assign wr_en_reg    = wr_en && (addr == A_EN);
  assign wr_vec       = wr_en && (addr == A_VEC);
  assign wr_sts       = wr_en && (addr == A_STS);
  assign unused_wdata = ^wdata;

  // write-one-to-clear strobes, one per source
  for (genvar g = 0; g < NSRC; g++) begin : g_clr
    assign clr_mask[g] = wr_sts && wdata[src_bit(g)];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_en <= '0;
      gie    <= 1'b0;
      mode   <= TRIG_LVL_HI;
      vector <= '0;
    end else begin
      if (wr_en_reg) begin
        for (int i = 0; i < NSRC; i++) src_en[i] <= wdata[src_bit(i)];
        gie  <= wdata[GIE_BIT];
        mode <= trig_mode_e'(wdata[MODE_LO+1:MODE_LO]);
      end
      if (wr_vec) vector <= wdata[VEC_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_EN: begin
        for (int i = 0; i < NSRC; i++) rd_mux[src_bit(i)] = src_en[i];
        rd_mux[MODE_LO+1:MODE_LO] = mode;
        rd_mux[GIE_BIT]           = gie;
      end
      A_VEC: rd_mux[VEC_W-1:0] = vector;
      A_STS: for (int i = 0; i < NSRC; i++) rd_mux[src_bit(i)] = status[i];
      A_CAP: rd_mux = CAP_VAL;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  // R3: capability read returns the fixed word
  a_r3_caps_fixed: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == A_CAP) |=> (rdata == CAP_VAL));
  // R2: vector write lands in the register
  a_r2_vector_write: assert property (@(posedge clk) disable iff (rst)
    wr_vec |=> (vector == $past(wdata[VEC_W-1:0])));

endmodule

// File: rtl/irq_trigger.sv
`timescale 1ns/1ps
module irq_trigger
  import irq_pkg::*;
#(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] status,
  input  logic [NSRC-1:0] src_en,
  input  logic            gie,
  input  trig_mode_e      mode,
  output logic            irq_out
);

  logic [NSRC-1:0] pend, pend_q;
  logic            active, fresh;

  assign pend   = gie ? (status & src_en) : '0;
  assign active = |pend;
  assign fresh  = |(pend & ~pend_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= '0;
      irq_out <= 1'b0;
    end else begin
      pend_q <= pend;
      case (mode)
        TRIG_LVL_HI:  irq_out <= active;
        TRIG_LVL_LO:  irq_out <= ~active;
        TRIG_EDGE_HI: irq_out <= fresh;
        default:      irq_out <= ~fresh;
      endcase
    end
  end

  // R7: no global enable -> idle level (mode bit 0 gives idle polarity)
  a_r7_global_gate: assert property (@(posedge clk) disable iff (rst)
    !gie |=> (irq_out == $past(mode[0])));
  // R8: high-level mode follows pending set
  a_r8_level_high: assert property (@(posedge clk) disable iff (rst)
    (mode == TRIG_LVL_HI && gie && |(status & src_en)) |=> irq_out);
  // R10: a rising pulse only follows a non-empty pending set
  a_r10_pulse_source: assert property (@(posedge clk) disable iff (rst)
    (mode == TRIG_EDGE_HI && $past(mode) == TRIG_EDGE_HI && irq_out) |-> (pend_q != '0));

endmodule

// File: rtl/irq_status_unit.sv
`timescale 1ns/1ps
module irq_status_unit
  import irq_pkg::*;
#(
  parameter int   ADDR_W       = 8,
  parameter int   DATA_W       = 32,
  parameter int   VEC_W        = 8,
  parameter logic BURST_STATIC = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NSRC-1:0]   ev_pulse,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_out
);

  logic [NSRC-1:0] status, src_en, clr_mask;
  logic            gie;
  trig_mode_e      mode;

  irq_status_bank #(.NSRC(NSRC)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .ev_pulse (ev_pulse),
    .clr_mask (clr_mask),
    .status   (status)
  );

  irq_ctrl_regs #(
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .VEC_W        (VEC_W),
    .BURST_STATIC (BURST_STATIC)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wdata    (wdata),
    .status   (status),
    .src_en   (src_en),
    .gie      (gie),
    .mode     (mode),
    .clr_mask (clr_mask),
    .rdata    (rdata)
  );

  irq_trigger #(.NSRC(NSRC)) u_trig (
    .clk     (clk),
    .rst     (rst),
    .status  (status),
    .src_en  (src_en),
    .gie     (gie),
    .mode    (mode),
    .irq_out (irq_out)
  );

endmodule

// File: tb/irq_status_unit_tb.sv
`timescale 1ns/1ps
module irq_status_unit_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  ev_pulse = '0;
  logic [31:0] rdata;
  logic        irq_out;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  irq_status_unit u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .ev_pulse(ev_pulse), .rdata(rdata), .irq_out(irq_out)
  );

  // monitor: pops the expected read result one cycle after the strobe
  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (rdata !== e) begin
        bad++;
        $display("FAIL %s: rdata=%h expected=%h", t, rdata, e);
      end
    end
  end

  task automatic bus_read(input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(t);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] ev);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; ev_pulse = ev;
    @(negedge clk);
    wr_en = 1'b0; ev_pulse = '0;
  endtask

  task automatic pulse(input logic [3:0] ev);
    @(negedge clk);
    ev_pulse = ev;
    @(negedge clk);
    ev_pulse = '0;
  endtask

  task automatic check_irq(input logic e, input string t);
    total++;
    if (irq_out !== e) begin
      bad++;
      $display("FAIL %s: irq_out=%b expected=%b", t, irq_out, e);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: run did not finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check_irq(1'b0, "R1 irq after reset");
    total++;
    if (rdata !== 32'h0) begin
      bad++;
      $display("FAIL R1: rdata=%h expected=%h", rdata, 32'h0);
    end
    bus_read(8'h08, 32'h0, "R1 enable reset");
    bus_read(8'h0C, 32'h0, "R1 vector reset");
    bus_read(8'h10, 32'h0, "R1 status reset");

    // R3 capability, read-only
    bus_read(8'h14, 32'h1FF, "R3 caps");
    bus_write(8'h14, 32'h0, 4'h0);
    bus_read(8'h14, 32'h1FF, "R3 caps after write");

    // R2 map and masks
    bus_read(8'h20, 32'h0, "R2 unmapped");
    bus_write(8'h08, 32'hFFFF_FFFF, 4'h0);
    bus_read(8'h08, 32'h8000_009F, "R2 enable mask");
    bus_write(8'h08, 32'h0, 4'h0);
    bus_write(8'h0C, 32'hABCD_EF5A, 4'h0);
    bus_read(8'h0C, 32'h0000_005A, "R2 vector");

    // R4 events set status regardless of enables
    pulse(4'b0001);
    pulse(4'b0010);
    pulse(4'b1100);
    bus_read(8'h10, 32'h87, "R4 status after events");
    check_irq(1'b0, "R7 no enables");

    // R5 write-one-to-clear
    bus_write(8'h10, 32'h01, 4'h0);
    bus_read(8'h10, 32'h86, "R5 clear bit0");
    bus_write(8'h10, 32'h0, 4'h0);
    bus_read(8'h10, 32'h86, "R5 zero write keeps");
    bus_write(8'h10, 32'h84, 4'h0);
    bus_read(8'h10, 32'h02, "R5 clear bits 7,2");

    // R6 set wins over clear
    bus_write(8'h10, 32'h80, 4'b1000);
    bus_read(8'h10, 32'h82, "R6 collision keeps bit7");
    bus_write(8'h10, 32'hFFFF_FFFF, 4'h0);
    bus_read(8'h10, 32'h0, "R5 clear all");

    // R7 global gate, R8 high level
    pulse(4'b0001);
    bus_write(8'h08, 32'h0000_0001, 4'h0);
    @(negedge clk); check_irq(1'b0, "R7 gie off");
    bus_write(8'h08, 32'h8000_0002, 4'h0);
    @(negedge clk); check_irq(1'b0, "R8 other source enabled");
    bus_write(8'h08, 32'h8000_0001, 4'h0);
    @(negedge clk); check_irq(1'b1, "R8 level high asserted");
    bus_write(8'h10, 32'h01, 4'h0);
    @(negedge clk); check_irq(1'b0, "R8 level high cleared");

    // R9 low level
    bus_write(8'h08, 32'h8000_0009, 4'h0);
    @(negedge clk); check_irq(1'b1, "R9 idle high");
    pulse(4'b0001);
    @(negedge clk); check_irq(1'b0, "R9 asserted low");
    bus_write(8'h10, 32'h01, 4'h0);
    @(negedge clk); check_irq(1'b1, "R9 released");

    // R10 rising pulse
    bus_write(8'h08, 32'h8000_0011, 4'h0);
    @(negedge clk); check_irq(1'b0, "R10 idle");
    pulse(4'b0001);
    @(negedge clk); check_irq(1'b1, "R10 pulse");
    @(negedge clk); check_irq(1'b0, "R10 pulse one cycle");
    pulse(4'b0001);
    @(negedge clk); check_irq(1'b0, "R10 repeat no pulse");
    pulse(4'b0010);
    @(negedge clk); check_irq(1'b0, "R10 disabled source");
    bus_write(8'h08, 32'h8000_0013, 4'h0);
    @(negedge clk); check_irq(1'b1, "R10 enable pending bit");
    @(negedge clk); check_irq(1'b0, "R10 pulse ends");

    // R11 falling pulse
    bus_write(8'h10, 32'hFF, 4'h0);
    bus_write(8'h08, 32'h8000_0019, 4'h0);
    @(negedge clk); check_irq(1'b1, "R11 idle high");
    pulse(4'b0001);
    @(negedge clk); check_irq(1'b0, "R11 low pulse");
    @(negedge clk); check_irq(1'b1, "R11 back high");
    bus_write(8'h08, 32'h0000_0019, 4'h0);
    @(negedge clk); check_irq(1'b1, "R7 falling idle with gie off");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      total++; bad++;
      $display("FAIL R2: reads missing=%0d expected=0", exp_q.size());
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule